// File: doc/BRIEF.md
# Serial Control Register Port

This block receives 16-bit control words on a three-wire serial link: a control clock, an active-low frame line and a data line. It decodes each word into one of four configuration registers and drives every field of those registers as a separate signal to the rest of an audio playback datapath. The four registers hold the left volume, the right volume, the converter settings and the clock-generator settings.

The serial pins do not depend on the system clock. All three pass through a two-flop synchroniser and are then sampled on the system clock `clk`, which must run well above twice the control clock rate. Each bit is taken on a rising edge of the control clock while the frame line is low. The word is applied when the frame line rises. The two least significant bits of the word are the register address and the bits above them are the payload. A frame that does not carry exactly sixteen bits is dropped.

Top module: `audio_ctl_port`

## Requirements
- R1: While `rst` is high, and after it falls until the first accepted word, both volumes read 0x3FFF, `word_len` reads 24 and every other output field reads 0.
- R2: Bits are taken MSB first on rising `ser_clk` edges while `ser_latch_n` is low. The word is applied on the rising edge of `ser_latch_n`, and the control clock may pause for any time between bits.
- R3: A frame that held fewer or more than 16 rising control-clock edges changes no output.
- R4: Word bits 1:0 pick the target: 00 is the left volume, 10 the right volume, 01 the converter register and 11 the clock register. Only the target changes.
- R5: A volume write loads word bits 15:2 into the 14-bit volume output.
- R6: A converter write maps word bits 11:10 to `interp_sel`, 9:8 to the width code, 7 to `out_invert`, 6 to `soft_mute`, 5:4 to `fmt_sel` and 3:2 to `deemph_sel`. Bits 15:12 are ignored.
- R7: `word_len` decodes the width code: 00 gives 24, 01 gives 20, and 10 or 11 give 16.
- R8: An interpolation code of 11 leaves `interp_sel` unchanged, while the other fields of that word are still applied.
- R9: A clock write maps word bit 11 to `pd_pll2`, 10 to `pd_pll1`, 9 to `pd_xtal`, 8 to `clk_halve`, 7:6 to `rate_sel`, 5 to `sclk1_384`, 4 to `fs_double`, 3 to `sclk2_fs` and 2 to `mclk_in`. Bits 15:12 are ignored.
- R10: A rate code of 01 leaves `rate_sel` unchanged, while the other fields of that word are still applied.
- R11: Control-clock edges while `ser_latch_n` is high change no output and do not count toward the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial control clock (asynchronous) |
| ser_latch_n | input | 1 | Active-low frame line; rising edge applies the word |
| ser_data | input | 1 | Serial data, MSB first |
| vol_left | output | 14 | Left channel volume |
| vol_right | output | 14 | Right channel volume |
| interp_sel | output | 2 | Interpolation factor code |
| word_len | output | 5 | Decoded serial audio word length in bits |
| out_invert | output | 1 | Output phase inversion |
| soft_mute | output | 1 | Soft mute request |
| fmt_sel | output | 2 | Serial audio format code |
| deemph_sel | output | 2 | De-emphasis selection code |
| pd_pll2 | output | 1 | Power down second PLL |
| pd_pll1 | output | 1 | Power down first PLL |
| pd_xtal | output | 1 | Power down crystal oscillator |
| clk_halve | output | 1 | Halve all generated clocks |
| rate_sel | output | 2 | Base sample-rate code |
| sclk1_384 | output | 1 | Audio clock at 384 fs instead of 256 fs |
| fs_double | output | 1 | Double the sample rate |
| sclk2_fs | output | 1 | Second clock follows 512 fs instead of fixed rate |
| mclk_in | output | 1 | Master clock pin used as input |

## Verification
The bench sweeps hundreds of converter and clock words in which every reserved code appears. A design that filtered the wrong field, or that dropped the whole word on a reserved code, would drift from the arithmetic model. It sends frames of 0, 15 and 17 bits. A bit counter that wrapped instead of saturating, or that committed on a count of at least sixteen, would corrupt a register there. It toggles the control clock with the frame line high, where a counter not cleared at frame start would shift the next word. It also stretches the gaps between bits, which catches a design that depends on a free-running control clock.

// File: rtl/actl_pkg.sv
package actl_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 2;
    localparam int VOL_W  = WORD_W - ADDR_W;

    typedef enum logic [ADDR_W-1:0] {
        SEL_VOL_L = 2'b00,
        SEL_DAC   = 2'b01,
        SEL_VOL_R = 2'b10,
        SEL_CLK   = 2'b11
    } reg_sel_e;

    // Packed in word order: bits 11 down to 2
    typedef struct packed {
        logic [1:0] interp;
        logic [1:0] width;
        logic       invert;
        logic       mute;
        logic [1:0] fmt;
        logic [1:0] deemph;
    } dac_cfg_t;

    typedef struct packed {
        logic       pd_pll2;
        logic       pd_pll1;
        logic       pd_xtal;
        logic       halve;
        logic [1:0] rate;
        logic       sclk1_384;
        logic       fs_double;
        logic       sclk2_fs;
        logic       mclk_in;
    } clk_cfg_t;

    localparam int CFG_W = $bits(dac_cfg_t);

    localparam logic [VOL_W-1:0] VOL_DEFAULT = '1;
    localparam dac_cfg_t         DAC_DEFAULT = '0;
    localparam clk_cfg_t         CLK_DEFAULT = '0;

    localparam logic [1:0] INTERP_RESERVED = 2'b11;
    localparam logic [1:0] RATE_RESERVED   = 2'b01;

    function automatic logic [4:0] decode_len(input logic [1:0] code);
        case (code)
            2'b00:   return 5'd24;
            2'b01:   return 5'd20;
            default: return 5'd16;
        endcase
    endfunction

    function automatic dac_cfg_t merge_dac(input dac_cfg_t cur, input dac_cfg_t nxt);
        dac_cfg_t r;
        r = nxt;
        if (nxt.interp == INTERP_RESERVED) r.interp = cur.interp;
        return r;
    endfunction

    function automatic clk_cfg_t merge_clk(input clk_cfg_t cur, input clk_cfg_t nxt);
        clk_cfg_t r;
        r = nxt;
        if (nxt.rate == RATE_RESERVED) r.rate = cur.rate;
        return r;
    endfunction

endpackage

// File: rtl/actl_sync.sv
module actl_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= RST_VAL;
        else     stage[0] <= din;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) stage[g] <= RST_VAL;
            else     stage[g] <= stage[g-1];
        end
    end

    assign dout = stage[STAGES-1];
endmodule

// File: rtl/actl_shift.sv
module actl_shift
    import actl_pkg::*;
#(
    parameter int W     = WORD_W,
    localparam int CNT_W = $clog2(W + 2)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sclk,
    input  logic         latch_n,
    input  logic         sdata,
    output logic [W-1:0] word,
    output logic         commit
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(W + 1);

    logic             sclk_q;
    logic             latch_q;
    logic [W-1:0]     shreg;
    logic [CNT_W-1:0] cnt;

    logic sclk_rise, latch_fall, latch_rise;
    assign sclk_rise  = sclk & ~sclk_q;
    assign latch_fall = ~latch_n & latch_q;
    assign latch_rise = latch_n & ~latch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            latch_q <= 1'b1;
            shreg   <= '0;
            cnt     <= '0;
        end else begin
            sclk_q  <= sclk;
            latch_q <= latch_n;
            if (latch_fall) begin
                cnt <= '0;
            end else if (sclk_rise && !latch_n) begin
                shreg <= {shreg[W-2:0], sdata};
                if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
            end
        end
    end

    assign commit = latch_rise && (cnt == CNT_FULL);
    assign word   = shreg;

    // R3: counter saturates at one past a full word
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_OVER);

    // R2: a commit is followed by the frame line seen high
    assert_commit_on_close_R2: assert property (@(posedge clk) disable iff (rst)
        commit |=> latch_q);

    // R11: frame line idle high leaves shifter state untouched
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (latch_q && latch_n) |=> ($stable(shreg) && $stable(cnt)));
endmodule

// File: rtl/actl_regs.sv
module actl_regs
    import actl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output logic [VOL_W-1:0] vol_l,
    output logic [VOL_W-1:0] vol_r,
    output dac_cfg_t         dac,
    output clk_cfg_t         ckc
);
    reg_sel_e         sel;
    logic [VOL_W-1:0] payload;
    dac_cfg_t         dac_in;
    clk_cfg_t         ckc_in;

    assign sel     = reg_sel_e'(wr_word[ADDR_W-1:0]);
    assign payload = wr_word[WORD_W-1:ADDR_W];
    assign dac_in  = dac_cfg_t'(payload[CFG_W-1:0]);
    assign ckc_in  = clk_cfg_t'(payload[CFG_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            vol_l <= VOL_DEFAULT;
            vol_r <= VOL_DEFAULT;
            dac   <= DAC_DEFAULT;
            ckc   <= CLK_DEFAULT;
        end else if (wr_en) begin
            case (sel)
                SEL_VOL_L: vol_l <= payload;
                SEL_VOL_R: vol_r <= payload;
                SEL_DAC:   dac   <= merge_dac(dac, dac_in);
                SEL_CLK:   ckc   <= merge_clk(ckc, ckc_in);
                default:   ;
            endcase
        end
    end

    // R8: reserved interpolation code never reaches the output
    assert_interp_legal_R8: assert property (@(posedge clk) disable iff (rst)
        dac.interp != INTERP_RESERVED);

    // R10: reserved rate code never reaches the output
    assert_rate_legal_R10: assert property (@(posedge clk) disable iff (rst)
        ckc.rate != RATE_RESERVED);

    // R4: without a write every register holds
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(vol_l) && $stable(vol_r) && $stable(dac) && $stable(ckc)));

    // R5: a left-volume write lands the payload
    assert_vol_load_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_VOL_L) |=> (vol_l == $past(payload)));
endmodule

// File: rtl/audio_ctl_port.sv
module audio_ctl_port
    import actl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ser_clk,
    input  logic        ser_latch_n,
    input  logic        ser_data,
    output logic [13:0] vol_left,
    output logic [13:0] vol_right,
    output logic [1:0]  interp_sel,
    output logic [4:0]  word_len,
    output logic        out_invert,
    output logic        soft_mute,
    output logic [1:0]  fmt_sel,
    output logic [1:0]  deemph_sel,
    output logic        pd_pll2,
    output logic        pd_pll1,
    output logic        pd_xtal,
    output logic        clk_halve,
    output logic [1:0]  rate_sel,
    output logic        sclk1_384,
    output logic        fs_double,
    output logic        sclk2_fs,
    output logic        mclk_in
);
    logic [2:0]        pins_s;
    logic [WORD_W-1:0] word;
    logic              commit;
    dac_cfg_t          dac;
    clk_cfg_t          ckc;

    actl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ser_clk, ser_latch_n, ser_data}),
        .dout (pins_s)
    );

    actl_shift #(.W(WORD_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .sclk    (pins_s[2]),
        .latch_n (pins_s[1]),
        .sdata   (pins_s[0]),
        .word    (word),
        .commit  (commit)
    );

    actl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (commit),
        .wr_word (word),
        .vol_l   (vol_left),
        .vol_r   (vol_right),
        .dac     (dac),
        .ckc     (ckc)
    );

    assign interp_sel = dac.interp;
    assign word_len   = decode_len(dac.width);
    assign out_invert = dac.invert;
    assign soft_mute  = dac.mute;
    assign fmt_sel    = dac.fmt;
    assign deemph_sel = dac.deemph;
    assign pd_pll2    = ckc.pd_pll2;
    assign pd_pll1    = ckc.pd_pll1;
    assign pd_xtal    = ckc.pd_xtal;
    assign clk_halve  = ckc.halve;
    assign rate_sel   = ckc.rate;
    assign sclk1_384  = ckc.sclk1_384;
    assign fs_double  = ckc.fs_double;
    assign sclk2_fs   = ckc.sclk2_fs;
    assign mclk_in    = ckc.mclk_in;

    // R7: decoded length is always one of the three legal values
    assert_len_legal_R7: assert property (@(posedge clk) disable iff (rst)
        (word_len == 5'd24) || (word_len == 5'd20) || (word_len == 5'd16));
endmodule

// File: tb/sim_audio_ctl_port.sv
module sim_audio_ctl_port;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_latch_n = 1'b1;
    logic ser_data = 1'b0;

    logic [13:0] vol_left, vol_right;
    logic [1:0]  interp_sel, fmt_sel, deemph_sel, rate_sel;
    logic [4:0]  word_len;
    logic out_invert, soft_mute, pd_pll2, pd_pll1, pd_xtal, clk_halve;
    logic sclk1_384, fs_double, sclk2_fs, mclk_in;

    always #2 clk = ~clk;

    audio_ctl_port u0 (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_latch_n(ser_latch_n),
        .ser_data(ser_data), .vol_left(vol_left), .vol_right(vol_right),
        .interp_sel(interp_sel), .word_len(word_len), .out_invert(out_invert),
        .soft_mute(soft_mute), .fmt_sel(fmt_sel), .deemph_sel(deemph_sel),
        .pd_pll2(pd_pll2), .pd_pll1(pd_pll1), .pd_xtal(pd_xtal),
        .clk_halve(clk_halve), .rate_sel(rate_sel), .sclk1_384(sclk1_384),
        .fs_double(fs_double), .sclk2_fs(sclk2_fs), .mclk_in(mclk_in)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // expected model
    logic [13:0] e_vl, e_vr;
    logic [1:0]  e_interp, e_width, e_fmt, e_deemph, e_rate;
    logic        e_inv, e_mute, e_p2, e_p1, e_px, e_half, e_s1, e_fsd, e_s2, e_mck;

    function automatic logic [4:0] exp_len(input logic [1:0] c);
        return (c == 2'd0) ? 5'd24 : (c == 2'd1) ? 5'd20 : 5'd16;
    endfunction

    function automatic logic [50:0] observed();
        return {vol_left, vol_right, interp_sel, word_len, out_invert, soft_mute,
                fmt_sel, deemph_sel, pd_pll2, pd_pll1, pd_xtal, clk_halve,
                rate_sel, sclk1_384, fs_double, sclk2_fs, mclk_in};
    endfunction

    function automatic logic [50:0] expected();
        return {e_vl, e_vr, e_interp, exp_len(e_width), e_inv, e_mute,
                e_fmt, e_deemph, e_p2, e_p1, e_px, e_half,
                e_rate, e_s1, e_fsd, e_s2, e_mck};
    endfunction

    task automatic model_reset();
        e_vl = 14'h3FFF; e_vr = 14'h3FFF;
        e_interp = 0; e_width = 0; e_fmt = 0; e_deemph = 0; e_rate = 0;
        e_inv = 0; e_mute = 0; e_p2 = 0; e_p1 = 0; e_px = 0; e_half = 0;
        e_s1 = 0; e_fsd = 0; e_s2 = 0; e_mck = 0;
    endtask

    task automatic model_write(input logic [15:0] w);
        case (w[1:0])
            2'b00: e_vl = w[15:2];
            2'b10: e_vr = w[15:2];
            2'b01: begin
                if (((w >> 10) & 3) != 3) e_interp = 2'((w >> 10) & 3);
                e_width  = 2'((w >> 8) & 3);
                e_inv    = w[7];
                e_mute   = w[6];
                e_fmt    = 2'((w >> 4) & 3);
                e_deemph = 2'((w >> 2) & 3);
            end
            default: begin
                e_p2   = w[11];
                e_p1   = w[10];
                e_px   = w[9];
                e_half = w[8];
                if (((w >> 6) & 3) != 1) e_rate = 2'((w >> 6) & 3);
                e_s1   = w[5];
                e_fsd  = w[4];
                e_s2   = w[3];
                e_mck  = w[2];
            end
        endcase
    endtask

    task automatic check(input string req, input logic [50:0] got, input logic [50:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    // send nbits bits: the first 16 come from w MSB first, extras are zeros
    task automatic send(input logic [15:0] w, input int nbits, input int gap);
        ser_latch_n = 1'b0;
        hold(4);
        for (int i = 0; i < nbits; i++) begin
            ser_data = (i < 16) ? w[15 - i] : 1'b0;
            ser_clk  = 1'b0;
            hold(3 + gap);
            ser_clk  = 1'b1;
            hold(3);
        end
        ser_clk = 1'b0;
        hold(3);
        ser_latch_n = 1'b1;
        hold(10);
    endtask

    task automatic write_check(input logic [15:0] w, input string req);
        send(w, 16, 0);
        model_write(w);
        check(req, observed(), expected());
    endtask

    initial begin
        model_reset();
        hold(3);
        check("R1 during reset", observed(), expected());
        rst = 1'b0;
        hold(6);
        check("R1 after reset", observed(), expected());

        // R5 and R4: volume sweep on both channels
        for (int i = 0; i < 40; i++) begin
            logic [13:0] v;
            v = 14'((i * 1237 + 3) % 16384);
            if (i == 0) v = 14'h0000;
            if (i == 1) v = 14'h3FFF;
            write_check({v, 2'b00}, "R5 R4 left volume");
            write_check({~v, 2'b10}, "R5 R4 right volume");
        end

        // R6 R7 R8: converter register sweep with junk in bits 15:12
        for (int i = 0; i < 256; i++) begin
            logic [9:0] body;
            body = 10'((i * 37 + 5) % 1024);
            write_check({4'(i), body, 2'b01}, "R6 R7 R8 converter fields");
        end

        // R9 R10: clock register sweep
        for (int i = 0; i < 256; i++) begin
            logic [9:0] body;
            body = 10'((i * 83 + 11) % 1024);
            write_check({4'(i + 7), body, 2'b11}, "R9 R10 clock fields");
        end

        // R8 explicit: reserved interp with other fields changing
        write_check(16'b0000_01_00_1_1_10_01_01, "R8 set interp 4x");
        write_check(16'b0000_11_10_0_0_01_10_01, "R8 reserved interp kept, rest applied");
        // R10 explicit
        write_check(16'b0000_0000_10_0000_11, "R10 set rate 32k");
        write_check(16'b0000_1111_01_1111_11, "R10 reserved rate kept, rest applied");

        // R3: short, long and empty frames are dropped
        send(16'h1234, 15, 0);
        check("R3 15-bit frame dropped", observed(), expected());
        send(16'h5678, 17, 0);
        check("R3 17-bit frame dropped", observed(), expected());
        send(16'h9ABC, 0, 0);
        check("R3 empty frame dropped", observed(), expected());
        write_check(16'h2468, "R3 full frame after bad frames");

        // R11: clock edges with frame line high
        for (int i = 0; i < 20; i++) begin
            ser_data = i[0];
            ser_clk = 1'b1; hold(3);
            ser_clk = 1'b0; hold(3);
        end
        check("R11 idle clocks ignored", observed(), expected());
        write_check(16'hABCE, "R11 next frame counts from zero");

        // R2: gated control clock with long pauses between bits
        send(16'h7FFC, 16, 40);
        model_write(16'h7FFC);
        check("R2 gated clock word", observed(), expected());

        // R1: reset again restores defaults
        rst = 1'b1;
        hold(3);
        rst = 1'b0;
        hold(3);
        model_reset();
        check("R1 second reset", observed(), expected());

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule